// File: doc/BRIEF.md
# Flag-Producing Byte ALU

This block is the arithmetic and logic stage of a small microcontroller core. Each cycle it takes two operands and an operation code, and it returns a result, a flag saying whether that result should go back to the register file, and the next carry and zero flag values. The carry and zero flags are held in registers inside the block. Conditional jumps, calls and returns read those flag registers.

The carry flag has a different meaning for each class of operation. For addition it is the carry out of the top bit. For subtraction and comparison it is the borrow, set when the subtrahend is larger. Logic operations always clear it. For the bit-test operations it is the odd parity of the masked value. The carry-chained variants use the stored carry as a carry-in or borrow-in, or fold it into the parity. They also keep the zero flag set only when every step of a multi-byte chain gave zero.

The flag registers change only in a cycle where the execute enable is high. Comparison and test operations produce flags but never a write-back.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, both `carry_q` and `zero_q` are cleared, whatever the other inputs are.
- R2: ADD (op 0) gives `result` = (a + b) mod 2^W. Its carry is the carry out of the top bit, and Z is set when `result` is zero.
- R3: ADDCY (op 1) adds the stored carry as carry-in. Its carry is the carry out, and Z is set only when `result` is zero and the stored Z was set.
- R4: SUB (op 2) gives `result` = (a - b) mod 2^W. Its carry is set when b > a (a borrow), and Z is set when `result` is zero.
- R5: SUBCY (op 3) subtracts b plus the stored carry. Its carry is set when b + carry > a, and Z is set only when `result` is zero and the stored Z was set.
- R6: AND (op 4), OR (op 5) and XOR (op 6) give the bitwise result, always clear the carry, and set Z when the result is zero.
- R7: COMPARE (op 7) and COMPARECY (op 8) produce the same flags as SUB and SUBCY, with `wr_en` low.
- R8: TEST (op 9) forms a & b. Z is set when that value is zero, the carry is its odd parity, and `wr_en` is low.
- R9: TESTCY (op 10) sets the carry to the odd parity of a & b together with the stored carry. Z is set only when a & b is zero and the stored Z was set. `wr_en` is low.
- R10: When `exec_en` is low, `carry_q` and `zero_q` keep their values at the clock edge.
- R11: Codes 11 to 15 are not operations. They drive `wr_en` low and `result` to zero, and the flags keep their values even when `exec_en` is high.
- R12: `wr_en` is high for op codes 0 to 6 and low for all other codes. `carry_nxt` and `zero_nxt` are the values that `carry_q` and `zero_q` take at the next enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | High in a cycle that executes an instruction |
| op_sel | input | 4 | Operation code |
| opa | input | DATA_W | First operand (minuend) |
| opb | input | DATA_W | Second operand (subtrahend) |
| result | output | DATA_W | Computed value |
| wr_en | output | 1 | Result should be written back |
| carry_nxt | output | 1 | Carry value for the next enabled edge |
| zero_nxt | output | 1 | Zero value for the next enabled edge |
| carry_q | output | 1 | Stored carry flag |
| zero_q | output | 1 | Stored zero flag |

## Verification
The bench builds the block with the default `DATA_W` of 8. At that width the operand corners can be driven directly: 0x00, 0xFF and 0x80, a borrow from equal operands when the carry is set, and a sum that is exactly 2^8. Multi-byte chains are built by running ADDCY, SUBCY and TESTCY after a seeding operation, so the chained-zero rule is exercised with both stored Z values. A pseudo-random sweep of operands across all eleven codes is checked against a reference model in the bench that uses integer arithmetic.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CMP  = 4'd7,
        OP_CMPC = 4'd8,
        OP_TST  = 4'd9,
        OP_TSTC = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_TEST  = 2'd2,
        CLS_NONE  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        LFN_AND = 2'd0,
        LFN_OR  = 2'd1,
        LFN_XOR = 2'd2
    } logic_fn_e;

    typedef struct packed {
        op_class_e cls;
        logic      subtract;
        logic      use_cin;
        logic      chain_z;
        logic      writes;
        logic_fn_e lfn;
    } op_ctrl_t;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;

    function automatic op_ctrl_t decode_op(input logic [3:0] code);
        op_ctrl_t d;
        d.cls      = CLS_NONE;
        d.subtract = 1'b0;
        d.use_cin  = 1'b0;
        d.chain_z  = 1'b0;
        d.writes   = 1'b0;
        d.lfn      = LFN_AND;
        case (code)
            OP_ADD:  begin d.cls = CLS_ARITH; d.writes = 1'b1; end
            OP_ADDC: begin d.cls = CLS_ARITH; d.writes = 1'b1;
                           d.use_cin = 1'b1; d.chain_z = 1'b1; end
            OP_SUB:  begin d.cls = CLS_ARITH; d.writes = 1'b1;
                           d.subtract = 1'b1; end
            OP_SUBC: begin d.cls = CLS_ARITH; d.writes = 1'b1;
                           d.subtract = 1'b1; d.use_cin = 1'b1;
                           d.chain_z = 1'b1; end
            OP_AND:  begin d.cls = CLS_LOGIC; d.writes = 1'b1; d.lfn = LFN_AND; end
            OP_OR:   begin d.cls = CLS_LOGIC; d.writes = 1'b1; d.lfn = LFN_OR; end
            OP_XOR:  begin d.cls = CLS_LOGIC; d.writes = 1'b1; d.lfn = LFN_XOR; end
            OP_CMP:  begin d.cls = CLS_ARITH; d.subtract = 1'b1; end
            OP_CMPC: begin d.cls = CLS_ARITH; d.subtract = 1'b1;
                           d.use_cin = 1'b1; d.chain_z = 1'b1; end
            OP_TST:  begin d.cls = CLS_TEST; d.lfn = LFN_AND; end
            OP_TSTC: begin d.cls = CLS_TEST; d.lfn = LFN_AND;
                           d.use_cin = 1'b1; d.chain_z = 1'b1; end
            default: d.cls = CLS_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              subtract,
    input  logic              use_cin,
    output logic [DATA_W-1:0] sum,
    output logic              cflag
);
    localparam int EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] b_eff;
    logic              chain_bit;
    logic              cin_eff;
    logic [EXT_W-1:0]  ext;

    // Subtraction runs as a + ~b + ~borrow_in; the borrow out is the inverted carry.
    always_comb begin
        chain_bit = use_cin & cin;
        b_eff     = subtract ? ~b : b;
        cin_eff   = subtract ? ~chain_bit : chain_bit;
        ext       = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
        sum       = ext[DATA_W-1:0];
        cflag     = subtract ? ~ext[DATA_W] : ext[DATA_W];
    end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_fn_e         fn,
    input  logic              cin,
    input  logic              use_cin,
    output logic [DATA_W-1:0] res,
    output logic              parity
);
    logic [DATA_W:0] par_chain;

    always_comb begin
        case (fn)
            LFN_OR:  res = a | b;
            LFN_XOR: res = a ^ b;
            default: res = a & b;
        endcase
    end

    // Parity chain, seeded with the stored carry for the chained test.
    assign par_chain[0] = use_cin & cin;
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_par
            assign par_chain[i+1] = par_chain[i] ^ res[i];
        end
    endgenerate
    assign parity = par_chain[DATA_W];

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
    import flag_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  flags_t nxt,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              carry_nxt,
    output logic              zero_nxt,
    output logic              carry_q,
    output logic              zero_q
);
    op_ctrl_t          ctrl;
    flags_t            fl_q;
    flags_t            fl_nxt;
    logic [DATA_W-1:0] arith_res;
    logic              arith_c;
    logic [DATA_W-1:0] logic_res;
    logic              logic_par;
    logic              res_zero;

    assign ctrl = decode_op(op_sel);

    flag_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a        (opa),
        .b        (opb),
        .cin      (fl_q.c),
        .subtract (ctrl.subtract),
        .use_cin  (ctrl.use_cin),
        .sum      (arith_res),
        .cflag    (arith_c)
    );

    flag_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a       (opa),
        .b       (opb),
        .fn      (ctrl.lfn),
        .cin     (fl_q.c),
        .use_cin (ctrl.use_cin),
        .res     (logic_res),
        .parity  (logic_par)
    );

    always_comb begin
        case (ctrl.cls)
            CLS_ARITH: result = arith_res;
            CLS_LOGIC: result = logic_res;
            CLS_TEST:  result = logic_res;
            default:   result = '0;
        endcase
        res_zero = (result == '0);
        case (ctrl.cls)
            CLS_ARITH: fl_nxt.c = arith_c;
            CLS_LOGIC: fl_nxt.c = 1'b0;
            CLS_TEST:  fl_nxt.c = logic_par;
            default:   fl_nxt.c = fl_q.c;
        endcase
        if (ctrl.cls == CLS_NONE) begin
            fl_nxt.z = fl_q.z;
        end else begin
            fl_nxt.z = res_zero & (~ctrl.chain_z | fl_q.z);
        end
    end

    flag_alu_flags u_flags (
        .clk (clk),
        .rst (rst),
        .en  (exec_en),
        .nxt (fl_nxt),
        .q   (fl_q)
    );

    assign wr_en     = ctrl.writes;
    assign carry_nxt = fl_nxt.c;
    assign zero_nxt  = fl_nxt.z;
    assign carry_q   = fl_q.c;
    assign zero_q    = fl_q.z;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              exec_en,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              carry_q,
    input logic              zero_q
);
    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (!carry_q && !zero_q));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> ($stable(carry_q) && $stable(zero_q)));

    // R6
    logic_clears_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (op_sel == 4'd4 || op_sel == 4'd5 || op_sel == 4'd6)) |=> !carry_q);

    // R4
    sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel == 4'd2) |=> (carry_q == ($past(opb) > $past(opa))));

    // R7
    cmp_equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel == 4'd7) |=> (zero_q == ($past(opa) == $past(opb))));

    // R8
    test_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel == 4'd9) |=> (carry_q == ^($past(opa) & $past(opb))));

    // R12
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel > 4'd6) |-> !wr_en);

    // R11
    undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel > 4'd10) |=> ($stable(carry_q) && $stable(zero_q)));

    // R11
    undef_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel > 4'd10) |-> (result == '0));

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .exec_en (exec_en),
    .op_sel  (op_sel),
    .opa     (opa),
    .opb     (opb),
    .result  (result),
    .wr_en   (wr_en),
    .carry_q (carry_q),
    .zero_q  (zero_q)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
    localparam int  W      = 8;
    localparam int  MOD    = 1 << W;
    localparam real HALF   = 2.5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         exec_en = 1'b0;
    logic [3:0]   op_sel = 4'd0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;
    logic         wr_en, carry_nxt, zero_nxt, carry_q, zero_q;

    int n_vec  = 0;
    int n_fail = 0;
    bit mc = 1'b0;
    bit mz = 1'b0;
    bit done = 1'b0;

    always #(HALF) clk = ~clk;

    flag_alu #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
        .opa(opa), .opb(opb), .result(result), .wr_en(wr_en),
        .carry_nxt(carry_nxt), .zero_nxt(zero_nxt),
        .carry_q(carry_q), .zero_q(zero_q)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int par_of(input int v);
        int p = 0;
        for (int i = 0; i < W; i++) p ^= (v >> i) & 1;
        return p;
    endfunction

    // Reference model: expected result, write, carry, zero from the requirements.
    task automatic model(input int op, input int a, input int b,
                         output int r, output int w, output int c, output int z);
        int t;
        bit chain;
        chain = (op == 1 || op == 3 || op == 8 || op == 10);
        w = (op <= 6);
        c = mc; z = mz; r = 0;
        case (op)
            0, 1: begin
                t = a + b + ((op == 1) ? int'(mc) : 0);
                r = t % MOD; c = (t >= MOD);
            end
            2, 3, 7, 8: begin
                t = a - b - ((op == 3 || op == 8) ? int'(mc) : 0);
                c = (t < 0); r = (t + MOD) % MOD;
            end
            4: begin r = a & b; c = 0; end
            5: begin r = a | b; c = 0; end
            6: begin r = a ^ b; c = 0; end
            9, 10: begin
                r = a & b;
                c = par_of(r) ^ ((op == 10) ? int'(mc) : 0);
            end
            default: r = 0;
        endcase
        if (op <= 10) z = (r == 0) && (!chain || mz);
    endtask

    // Drive at a falling edge, check combinational outputs, then the stored flags.
    task automatic apply(input string tag, input int op, input int a, input int b, input bit en);
        int r, w, c, z;
        op_sel = op[3:0]; opa = a[W-1:0]; opb = b[W-1:0]; exec_en = en;
        model(op, a, b, r, w, c, z);
        #1;
        check(tag, "result", int'(result), r);
        check(tag, "wr_en", int'(wr_en), w);
        check(tag, "carry_nxt", int'(carry_nxt), c);
        check(tag, "zero_nxt", int'(zero_nxt), z);
        @(posedge clk);
        if (en) begin mc = c[0]; mz = z[0]; end
        #1;
        check(tag, "carry_q", int'(carry_q), int'(mc));
        check(tag, "zero_q", int'(zero_q), int'(mz));
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; exec_en = 1'b1; op_sel = 4'd0; opa = '1; opb = 8'h01;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "carry_q", int'(carry_q), 0);
        check("R1", "zero_q", int'(zero_q), 0);
        @(negedge clk);
        rst = 1'b0; exec_en = 1'b0;
        mc = 0; mz = 0;
    endtask

    task automatic t_add();
        apply("R2", 0, 8'h12, 8'h34, 1);
        apply("R2", 0, 8'hFF, 8'h01, 1);
        apply("R2", 0, 8'h80, 8'h80, 1);
        apply("R2", 0, 8'h00, 8'h00, 1);
        apply("R12", 0, 8'hF0, 8'h0F, 1);
    endtask

    task automatic t_addcy();
        apply("R3", 0, 8'hFF, 8'h01, 1);   // C=1, Z=1
        apply("R3", 1, 8'hFF, 8'h00, 1);   // chain zero with carry out
        apply("R3", 1, 8'h00, 8'h00, 1);   // carry in 1 -> result 1
        apply("R3", 0, 8'hFF, 8'h02, 1);   // C=1, Z=0
        apply("R3", 1, 8'hFF, 8'h00, 1);   // zero but prior Z clear
    endtask

    task automatic t_sub();
        apply("R4", 2, 8'h50, 8'h20, 1);
        apply("R4", 2, 8'h20, 8'h50, 1);
        apply("R4", 2, 8'h77, 8'h77, 1);
        apply("R4", 2, 8'h00, 8'hFF, 1);
    endtask

    task automatic t_subcy();
        apply("R5", 2, 8'h00, 8'h01, 1);   // C=1, Z=0
        apply("R5", 3, 8'h05, 8'h05, 1);   // borrow from equal operands
        apply("R5", 2, 8'h10, 8'h10, 1);   // C=0, Z=1
        apply("R5", 3, 8'h33, 8'h33, 1);   // chained zero
        apply("R5", 2, 8'h00, 8'h01, 1);
        apply("R5", 3, 8'h01, 8'h00, 1);   // zero but prior Z clear
    endtask

    task automatic t_logic();
        apply("R6", 2, 8'h00, 8'h01, 1);   // set carry first
        apply("R6", 4, 8'hF0, 8'h0F, 1);
        apply("R6", 2, 8'h00, 8'h01, 1);
        apply("R6", 5, 8'hA0, 8'h05, 1);
        apply("R6", 2, 8'h00, 8'h01, 1);
        apply("R6", 6, 8'h5A, 8'h5A, 1);
        apply("R6", 6, 8'hFF, 8'h01, 1);
    endtask

    task automatic t_compare();
        apply("R7", 7, 8'h40, 8'h40, 1);
        apply("R7", 7, 8'h10, 8'h90, 1);
        apply("R7", 8, 8'h91, 8'h90, 1);   // equal after borrow, prior Z clear
        apply("R7", 7, 8'h22, 8'h22, 1);
        apply("R7", 8, 8'h22, 8'h22, 1);
    endtask

    task automatic t_test();
        apply("R8", 9, 8'hFF, 8'h07, 1);   // parity of 3 bits
        apply("R8", 9, 8'hF0, 8'h0F, 1);   // zero, even
        apply("R8", 9, 8'h81, 8'hFF, 1);   // two bits
    endtask

    task automatic t_testcy();
        apply("R9", 2, 8'h00, 8'h01, 1);   // C=1, Z=0
        apply("R9", 10, 8'h03, 8'h01, 1);  // one bit xor carry
        apply("R9", 9, 8'h00, 8'hFF, 1);   // Z=1, C=0
        apply("R9", 10, 8'h0F, 8'hF0, 1);  // chained zero
        apply("R9", 2, 8'h00, 8'h01, 1);
        apply("R9", 10, 8'h00, 8'h00, 1);  // carry alone gives parity 1
    endtask

    task automatic t_hold();
        apply("R10", 2, 8'h00, 8'h01, 1);
        apply("R10", 0, 8'h00, 8'h00, 0);
        apply("R10", 4, 8'h00, 8'h00, 0);
        apply("R10", 9, 8'h00, 8'h00, 1);
        apply("R10", 2, 8'h00, 8'h01, 0);
    endtask

    task automatic t_undef();
        apply("R11", 2, 8'h00, 8'h01, 1);
        for (int k = 11; k < 16; k++) apply("R11", k, 8'hAA, 8'h55, 1);
        apply("R11", 4, 8'h00, 8'h00, 1);
        for (int k = 11; k < 16; k++) apply("R11", k, 8'h00, 8'h00, 1);
    endtask

    task automatic t_sweep();
        logic [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply("R12", int'(lfsr[3:0]) % 11, int'(lfsr[15:8]), int'(lfsr[11:4]), lfsr[0] | lfsr[5]);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #(HALF * 2.0 * 100000.0);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_add();
        t_addcy();
        t_sub();
        t_subcy();
        t_logic();
        t_compare();
        t_test();
        t_testcy();
        t_hold();
        t_undef();
        t_sweep();
        done = 1'b1;
        finish_run();
    end

endmodule